// File: doc/BRIEF.md
# Flash Write-Status Read Generator

This block forms the 16-bit word returned to a host that reads a NOR-style flash array while an embedded program or erase is in flight, or while an erase is held in suspension. A command decoder elsewhere supplies the operating state and the latched erase target. The array supplies the stored word. This block decides, on each read strobe, whether the word is plain array data or a status word. In a status word, bits 7, 6 and 2 carry progress flags and every other bit passes straight through.

There are two toggle flops. The busy toggle (bit 6) flips on every status read while an operation runs. The region toggle (bit 2) flips only when the read address lies inside the region being erased or held suspended. A host polls with a few reads. If bit 6 moves, an operation is active. If bit 2 moves, the read hit the erase target, and bits 7 and 6 then tell an active erase apart from a suspended one. A program shows a moving bit 6 while bit 2 stays still. The read word is registered and appears with `rd_valid` one clock after `rd_stb`.

Top module: `flash_status_read`

## Requirements
- R1: After a synchronous active-low reset, `rd_valid` is 0 and `rd_word` is 0.
- R2: In state idle (`op_state`=0), a strobed read returns `arr_data` unchanged. `rd_valid` is 1 exactly in the cycle after each cycle with `rd_stb`=1, and 0 otherwise.
- R3: In state programming (`op_state`=1), every read returns bit 7 as the inverse of `prog_d7`.
- R4: In state erasing (`op_state`=2), every read returns bit 7 = 0, whatever the address.
- R5: Bit 6 of a program or erase status word alternates on successive status reads.
- R6: Bit 2 changes only on reads that hit the erase region while erasing (2), suspended (3) or suspended-with-program (4). During program status reads and reads outside the region, it holds its value.
- R7: In states 3 and 4, a read inside the suspended region returns bit 7 = 1 and bit 6 = 1.
- R8: In state suspended (`op_state`=3), a read outside the suspended region returns `arr_data` unchanged.
- R9: In state 4, a read outside the suspended region returns program status: bit 7 = inverse of `prog_d7`, bit 6 toggling. `prog_addr` never lies in the suspended region in this state.
- R10: The region test compares `rd_addr` with `er_addr` on bits ADDR_W-1..11 when `er_kind`=0 (sector), on bits ADDR_W-1..15 when `er_kind`=1 (block), and matches every address when `er_kind`=2 (whole array).
- R11: In every status word, all bits other than 7, 6 and 2 equal `arr_data`.
- R12: Entering state 1, 2 or 4 from any other state clears the busy toggle, so the first status read there shows bit 6 = 0. Entering state 2 from idle clears the region toggle, so the first in-region read shows bit 2 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_state | input | 3 | 0 idle, 1 programming, 2 erasing, 3 erase suspended, 4 programming while erase suspended |
| er_kind | input | 2 | Erase granularity: 0 sector, 1 block, 2 whole array |
| er_addr | input | ADDR_W | Latched erase target address |
| prog_addr | input | ADDR_W | Word address being programmed |
| prog_d7 | input | 1 | Bit 7 of the word being programmed |
| rd_addr | input | ADDR_W | Read address |
| arr_data | input | DATA_W | Array word at `rd_addr` |
| rd_stb | input | 1 | Read strobe, one per read |
| rd_word | output | DATA_W | Registered read word |
| rd_valid | output | 1 | `rd_word` updated this cycle |

## Verification
The embedded assertions check the following on every cycle: the fixed status values (bit 7 during program and erase, the 1/1 pattern on suspended-region hits), the pass-through of data bits, the one-cycle valid timing, the clearing of the toggles on entry, and that a program during suspension never targets the suspended region. Other behaviours appear only across sequences of reads, so the bench scenarios must show them. These include whether bit 6 and bit 2 move or hold over several polls, how sector, block and whole-array granularity changes which addresses move bit 2, and how the toggles carry across suspend and resume.

// File: rtl/fstat_pkg.sv
// Shared encodings for the flash write-status read generator.
// Assumes the command decoder drives op_state and er_kind with these codes.
package fstat_pkg;

    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_PROG      = 3'd1,
        OP_ERASE     = 3'd2,
        OP_SUSP      = 3'd3,
        OP_SUSP_PROG = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        EK_SECTOR = 2'd0,
        EK_BLOCK  = 2'd1,
        EK_CHIP   = 2'd2
    } ek_e;

    typedef enum logic [1:0] {
        RC_DATA     = 2'd0,
        RC_PROG     = 2'd1,
        RC_ERASE    = 2'd2,
        RC_SUSP_HIT = 2'd3
    } rclass_e;

    localparam int POLL_BIT = 7;
    localparam int BUSY_BIT = 6;
    localparam int REGN_BIT = 2;

    localparam int TGL_BUSY = 0;
    localparam int TGL_REGN = 1;
    localparam int TGL_NUM  = 2;

endpackage

// File: rtl/fs_region_match.sv
// Region comparator: reports whether a probe address lies in the erase
// region described by a base address and an erase granularity.
// Assumes SECT_LSB <= BLK_LSB < ADDR_W.
module fs_region_match
    import fstat_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int SECT_LSB = 11,
    parameter int BLK_LSB  = 15
) (
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] probe,
    output logic              hit
);

    localparam int SECT_W = ADDR_W - SECT_LSB;
    localparam int BLK_W  = ADDR_W - BLK_LSB;

    logic [SECT_W-1:0] sect_base, sect_probe;
    logic [BLK_W-1:0]  blk_base, blk_probe;

    // Slice the upper address fields for each granularity.
    always_comb begin
        sect_base  = base[ADDR_W-1:SECT_LSB];
        sect_probe = probe[ADDR_W-1:SECT_LSB];
        blk_base   = base[ADDR_W-1:BLK_LSB];
        blk_probe  = probe[ADDR_W-1:BLK_LSB];
    end

    // Select the comparison that matches the erase granularity.
    always_comb begin
        case (kind)
            EK_SECTOR: hit = (sect_base == sect_probe);
            EK_BLOCK:  hit = (blk_base == blk_probe);
            EK_CHIP:   hit = 1'b1;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/fs_toggle_bank.sv
// Bank of status toggle flops. Each flop flips once per advance pulse and
// is forced to 0 on its clear pulse. The "cur" output is the value the
// current read must show: 0 in a clear cycle, else the stored value.
// Assumes advance pulses come only from read strobes.
module fs_toggle_bank #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] clr,
    input  logic [NUM-1:0] adv,
    output logic [NUM-1:0] cur
);

    logic [NUM-1:0] q;

    for (genvar i = 0; i < NUM; i++) begin : g_tgl
        // Value visible to a read in this cycle.
        always_comb cur[i] = clr[i] ? 1'b0 : q[i];

        // Store the value after this cycle's possible flip.
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= cur[i] ^ adv[i];
        end

        AST_CLR_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] |=> (q[i] == $past(adv[i])));                       // R12

        AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[i] && !adv[i]) |=> $stable(q[i]));                   // R6
    end

endmodule

// File: rtl/fs_word_mux.sv
// Status word composer: replaces the poll, busy and region bits of the
// array word according to the read class; other bits pass through.
// Assumes DATA_W > POLL_BIT.
module fs_word_mux
    import fstat_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [1:0]        rclass,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              prog_d7,
    input  logic              busy_tgl,
    input  logic              regn_tgl,
    output logic [DATA_W-1:0] word
);

    // Overlay the three status bits for each read class.
    always_comb begin
        word = arr_data;
        case (rclass)
            RC_PROG: begin
                word[POLL_BIT] = ~prog_d7;
                word[BUSY_BIT] = busy_tgl;
                word[REGN_BIT] = regn_tgl;
            end
            RC_ERASE: begin
                word[POLL_BIT] = 1'b0;
                word[BUSY_BIT] = busy_tgl;
                word[REGN_BIT] = regn_tgl;
            end
            RC_SUSP_HIT: begin
                word[POLL_BIT] = 1'b1;
                word[BUSY_BIT] = 1'b1;
                word[REGN_BIT] = regn_tgl;
            end
            default: word = arr_data;
        endcase
    end

endmodule

// File: rtl/flash_status_read.sv
// Flash write-status read generator (top). Classifies each read from the
// operating state and the erase-region test, drives the two toggle flops
// and registers the composed read word one cycle after the strobe.
// Assumes op_state/er_kind/er_addr are stable from the decoder and that
// arr_data is valid in the strobe cycle.
module flash_status_read
    import fstat_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 11,
    parameter int BLK_LSB  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_state,
    input  logic [1:0]        er_kind,
    input  logic [ADDR_W-1:0] er_addr,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic              prog_d7,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_word,
    output logic              rd_valid
);

    op_e            st, st_q;
    logic           rd_hit, prog_hit;
    logic [1:0]     rclass;
    logic           busy_now, erase_ctx, entry_busy, entry_erase;
    logic [TGL_NUM-1:0] t_clr, t_adv, t_cur;
    logic [DATA_W-1:0]  word_d;

    // Interpret the state code.
    always_comb st = op_e'(op_state);

    // Remember the previous state to detect entry into busy states.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= OP_IDLE;
        else        st_q <= st;
    end

    // Region test of the read address against the erase target.
    fs_region_match #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB))
        i_rd_match (.kind(er_kind), .base(er_addr), .probe(rd_addr), .hit(rd_hit));

    // Region test of the program target, used to guard suspend-program.
    fs_region_match #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB))
        i_pg_match (.kind(er_kind), .base(er_addr), .probe(prog_addr), .hit(prog_hit));

    // Decode state groups and entry events.
    always_comb begin
        busy_now    = (st == OP_PROG) || (st == OP_ERASE) || (st == OP_SUSP_PROG);
        erase_ctx   = (st == OP_ERASE) || (st == OP_SUSP) || (st == OP_SUSP_PROG);
        entry_busy  = busy_now && (st != st_q);
        entry_erase = (st == OP_ERASE) && (st_q == OP_IDLE);
    end

    // Classify the read from state and region hit.
    always_comb begin
        case (st)
            OP_PROG:      rclass = RC_PROG;
            OP_ERASE:     rclass = RC_ERASE;
            OP_SUSP:      rclass = rd_hit ? RC_SUSP_HIT : RC_DATA;
            OP_SUSP_PROG: rclass = rd_hit ? RC_SUSP_HIT : RC_PROG;
            default:      rclass = RC_DATA;
        endcase
    end

    // Toggle control: busy toggle on status reads, region toggle on hits.
    always_comb begin
        t_clr = '0;
        t_adv = '0;
        t_clr[TGL_BUSY] = entry_busy;
        t_clr[TGL_REGN] = entry_erase;
        t_adv[TGL_BUSY] = rd_stb && ((rclass == RC_PROG) || (rclass == RC_ERASE));
        t_adv[TGL_REGN] = rd_stb && rd_hit && erase_ctx;
    end

    fs_toggle_bank #(.NUM(TGL_NUM))
        i_tgl (.clk(clk), .rst_n(rst_n), .clr(t_clr), .adv(t_adv), .cur(t_cur));

    fs_word_mux #(.DATA_W(DATA_W))
        i_mux (.rclass(rclass), .arr_data(arr_data), .prog_d7(prog_d7),
               .busy_tgl(t_cur[TGL_BUSY]), .regn_tgl(t_cur[TGL_REGN]),
               .word(word_d));

    // Register the read word and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_word <= word_d;
        end
    end

    AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);                                           // R2

    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_valid);                                         // R2

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && st == OP_IDLE) |=> (rd_word == $past(arr_data)));    // R2

    AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && st == OP_PROG) |=> (rd_word[POLL_BIT] == !$past(prog_d7))); // R3

    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && st == OP_ERASE) |=> (rd_word[POLL_BIT] == 1'b0));    // R4

    AST_SUSP_HIT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (st == OP_SUSP || st == OP_SUSP_PROG) && rd_hit)
        |=> (rd_word[POLL_BIT:BUSY_BIT] == 2'b11));                     // R7

    AST_UPPER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_word[DATA_W-1:POLL_BIT+1] == $past(arr_data[DATA_W-1:POLL_BIT+1]))); // R11

    AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_word[1:0] == $past(arr_data[1:0])));             // R11

    AST_SUSP_PROG_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OP_SUSP_PROG) |-> !prog_hit);                            // R9

endmodule

// File: tb/test_flash_status_read.sv
`timescale 1ns/1ps
module test_flash_status_read;

    localparam int AW = 21;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_state = 3'd0;
    logic [1:0]    er_kind = 2'd0;
    logic [AW-1:0] er_addr = '0;
    logic [AW-1:0] prog_addr = '0;
    logic          prog_d7 = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] arr_data = '0;
    logic          rd_stb = 1'b0;
    logic [DW-1:0] rd_word;
    logic          rd_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model state
    int   m_st = 0;
    logic m_t6 = 1'b0;
    logic m_t2 = 1'b0;

    always #2.5 clk = ~clk;

    flash_status_read i_flash_status_read (
        .clk(clk), .rst_n(rst_n), .op_state(op_state), .er_kind(er_kind),
        .er_addr(er_addr), .prog_addr(prog_addr), .prog_d7(prog_d7),
        .rd_addr(rd_addr), .arr_data(arr_data), .rd_stb(rd_stb),
        .rd_word(rd_word), .rd_valid(rd_valid));

    task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit in_region(logic [AW-1:0] a);
        case (er_kind)
            2'd0: return a[AW-1:11] == er_addr[AW-1:11];
            2'd1: return a[AW-1:15] == er_addr[AW-1:15];
            2'd2: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Expected word plus requirement tag; advances the model toggles.
    function automatic logic [DW-1:0] expect_read(logic [AW-1:0] a, logic [DW-1:0] d,
                                                  output string req);
        logic [DW-1:0] w;
        bit hit, ectx;
        w = d;
        hit = in_region(a);
        ectx = (m_st == 2) || (m_st == 3) || (m_st == 4);
        req = "R2";
        if (m_st == 1 || (m_st == 4 && !hit)) begin
            w[7] = ~prog_d7; w[6] = m_t6; w[2] = m_t2;
            req = (m_st == 1) ? "R3" : "R9";
            m_t6 = ~m_t6;
        end else if (m_st == 2) begin
            w[7] = 1'b0; w[6] = m_t6; w[2] = m_t2;
            req = "R4";
            m_t6 = ~m_t6;
        end else if ((m_st == 3 || m_st == 4) && hit) begin
            w[7] = 1'b1; w[6] = 1'b1; w[2] = m_t2;
            req = "R7";
        end else if (m_st == 3) begin
            req = "R8";
        end
        if (hit && ectx) m_t2 = ~m_t2;
        return w;
    endfunction

    // Change state at a negedge and let one clock pass.
    task automatic go(int s);
        op_state = 3'(s);
        if ((s == 1 || s == 2 || s == 4) && s != m_st) m_t6 = 1'b0;
        if (s == 2 && m_st == 0) m_t2 = 1'b0;
        m_st = s;
        @(negedge clk);
    endtask

    task automatic rd(logic [AW-1:0] a, logic [DW-1:0] d, output logic [DW-1:0] got);
        logic [DW-1:0] exp;
        string req;
        rd_addr = a; arr_data = d; rd_stb = 1'b1;
        exp = expect_read(a, d, req);
        @(negedge clk);
        rd_stb = 1'b0;
        got = rd_word;
        chk(rd_word == exp, req, rd_word, exp);
        chk(rd_valid == 1'b1, "R2 valid", {15'd0, rd_valid}, 16'd1);
    endtask

    logic [DW-1:0] g0, g1, g2;

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rd_word == '0 && rd_valid == 1'b0, "R1", rd_word, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: idle pass-through, valid drops without a strobe
        rd(21'h01234, 16'hA5C3, g0);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R2 no strobe", {15'd0, rd_valid}, 16'd0);

        // R3 R5 R12 R6: program, bit6 starts at 0 and alternates, bit2 still
        prog_d7 = 1'b1; prog_addr = 21'h00100;
        go(1);
        rd(21'h00100, 16'hFFFF, g0);
        rd(21'h00100, 16'hFFFF, g1);
        rd(21'h00100, 16'hFFFF, g2);
        chk(g0[6] == 1'b0, "R12 first bit6", g0, 16'h0);
        chk(g0[6] != g1[6] && g1[6] != g2[6], "R5 bit6 alternates", g1, ~g0);
        chk(g0[2] == g1[2] && g1[2] == g2[2], "R6 bit2 holds in program", g1, g0);
        go(0);

        // R4 R10: sector erase; neighbouring sector in same block must not move bit2
        er_kind = 2'd0; er_addr = 21'h0A800;
        go(2);
        rd(21'h0A8F0, 16'h1234, g0);
        rd(21'h0A8F0, 16'h1234, g1);
        chk(g0[2] == 1'b0 && g1[2] == 1'b1, "R12 R6 bit2 toggles on hit", g1, 16'h4);
        rd(21'h0B000, 16'h1234, g0);
        rd(21'h0B000, 16'h1234, g1);
        chk(g0[2] == g1[2], "R10 sector miss holds bit2", g1, g0);
        // R7 R8: suspend
        go(3);
        rd(21'h0A801, 16'h0000, g0);
        rd(21'h13579, 16'h5A5A, g1);
        chk(g1 == 16'h5A5A, "R8 outside returns data", g1, 16'h5A5A);
        // R9: program outside suspended region
        prog_d7 = 1'b0; prog_addr = 21'h1F000;
        go(4);
        rd(21'h1F000, 16'hFF7F, g0);
        rd(21'h0A802, 16'hFFFF, g1);
        go(3);
        go(2);
        go(0);

        // R10: block erase; other sector of same block moves bit2
        er_kind = 2'd1; er_addr = 21'h18000;
        go(2);
        rd(21'h1C000, 16'h00FF, g0);
        rd(21'h1F800, 16'h00FF, g1);
        chk(g0[2] != g1[2], "R10 block hit moves bit2", g1, ~g0);
        rd(21'h20000, 16'h00FF, g0);
        go(0);
        // R10: whole-array erase hits anywhere
        er_kind = 2'd2;
        go(2);
        rd(21'h00001, 16'hF0F0, g0);
        rd(21'h1FFFF, 16'hF0F0, g1);
        chk(g0[2] != g1[2], "R10 whole array hits", g1, ~g0);
        go(0);

        // Random mix: R2..R11 through the model
        for (int i = 0; i < 600; i++) begin
            int act;
            act = int'($urandom % 5);
            if (act == 0) begin
                case (m_st)
                    0: begin
                        if ($urandom % 2) begin
                            prog_d7 = 1'($urandom); prog_addr = AW'($urandom);
                            go(1);
                        end else begin
                            er_kind = 2'($urandom % 3); er_addr = AW'($urandom);
                            go(2);
                        end
                    end
                    1: go(0);
                    2: go(($urandom % 2) ? 0 : 3);
                    3: begin
                        if (er_kind != 2'd2 && ($urandom % 2)) begin
                            prog_d7 = 1'($urandom);
                            prog_addr = er_addr ^ (AW'(1) << (AW - 1));
                            go(4);
                        end else go(2);
                    end
                    default: go(3);
                endcase
            end else begin
                logic [AW-1:0] a;
                a = AW'($urandom);
                if ($urandom % 2) a[AW-1:11] = er_addr[AW-1:11];
                rd(a, DW'($urandom), g0);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule